// File: doc/BRIEF.md
# Saturating Fractional Multiply-Accumulate

This block multiplies two signed Q1.15 fractions and adds the product to a 16-bit addend, clamping twice: once after the multiply and once after the add. Both clamps happen within one clock cycle, and the clamped total lands in an accumulator register. The multiply never resolves its own carries. It hands a sum vector, a carry vector and one low-order carry bit to a 3:2 compressor that also takes the addend. A single carry-propagate adder then forms the total. Add overflow is judged from three sign bits: the addend sign, the sign of the clamped product, and the sign of the total.

The addend is either the block's own accumulator, for running sums, or an external value supplied on `acc_in`, for one-shot multiply-add. The accumulator updates only when enabled and can be cleared synchronously. The result appears on `mac_out` one cycle after the operands are presented.

Top module: `sat_mac`

## Requirements
- R1: While reset is held and on the first cycle after it, `mac_out` reads 0x0000.
- R2: When no clamp applies, the value written is the addend plus floor(op_a*op_b / 2^15), kept to 16 bits. Negative products therefore round toward minus infinity. The value is visible on `mac_out` one clock edge after the operands.
- R3: The product of 0x8000 by 0x8000 is clamped to 0x7FFF before it is added. Example: 0x7FFF plus an addend of 0xFFFF gives 0x7FFE.
- R4: If the addend and the clamped product are both non-negative and their true sum exceeds 0x7FFF, the value written is 0x7FFF.
- R5: If the addend and the clamped product are both negative and their true sum is below -32768, the value written is 0x8000.
- R6: With `acc_src`=1 the addend is `acc_in`. With `acc_src`=0 it is the current accumulator value, and `acc_in` has no effect.
- R7: With `acc_en`=0 and `acc_clr`=0, `mac_out` holds its value whatever the operands are.
- R8: With `acc_clr`=1, the accumulator becomes 0x0000 at the next edge. This takes priority over `acc_en`.
- R9: For every operand pair and addend, the written value equals a serial reference: multiply with clamp, then add with clamp.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_a | input | 16 | Multiplicand, Q1.15 |
| op_b | input | 16 | Multiplier, Q1.15 |
| acc_in | input | 16 | External addend, Q1.15 |
| acc_src | input | 1 | 1 selects `acc_in` as the addend, 0 selects the accumulator |
| acc_en | input | 1 | Write the clamped total into the accumulator |
| acc_clr | input | 1 | Synchronous clear, overrides `acc_en` |
| mac_out | output | 16 | Accumulator value |

## Verification
The product clamp and the add clamp can both act in the same cycle. For example, an addend of 0x0001 on top of the squared most-negative value needs the first clamp to fire, and then the second. The bench provokes this with directed addends around the squared minimum. It also sweeps corner operands (0, ±1 LSB, the extremes and halves) against addends at and near both rails. Each result is judged against a reference written as plain integer arithmetic, applying the two clamps in sequence. Clear and enable are also raised together, and the output must read zero.

// File: rtl/sat_mac_pkg.sv
package sat_mac_pkg;

  localparam int unsigned DEF_W = 16;

  typedef enum logic {
    SRC_REG = 1'b0,
    SRC_EXT = 1'b1
  } addend_src_e;

endpackage

// File: rtl/csa3.sv
module csa3 #(
  parameter int unsigned N = 16
) (
  input  logic [N-1:0] in_x,
  input  logic [N-1:0] in_y,
  input  logic [N-1:0] in_z,
  output logic [N-1:0] out_s,
  output logic [N-1:0] out_c
);

  logic [N-1:0] maj;

  generate
    for (genvar b = 0; b < N; b++) begin : g_bit
      assign out_s[b] = in_x[b] ^ in_y[b] ^ in_z[b];
      assign maj[b]   = (in_x[b] & in_y[b]) | (in_x[b] & in_z[b]) | (in_y[b] & in_z[b]);
    end
  endgenerate

  // carries move one column up; the top carry leaves the modular window
  assign out_c = {maj[N-2:0], 1'b0};

endmodule

// File: rtl/frac_mul_cs.sv
module frac_mul_cs #(
  parameter int unsigned W = 16
) (
  input  logic [W-1:0] mul_a,
  input  logic [W-1:0] mul_b,
  output logic [W-1:0] vec_s,
  output logic [W-1:0] vec_c,
  output logic         vec_cin,
  output logic         prod_neg,
  output logic         sat_hit
);

  localparam int unsigned PW   = 2 * W;
  localparam int unsigned ROWS = W + 1;
  localparam int unsigned FB   = W - 1;
  localparam logic [W-1:0] Q_MAX = {1'b0, {(W-1){1'b1}}};
  localparam logic [W-1:0] Q_MIN = {1'b1, {(W-1){1'b0}}};

  // carry out of the discarded low columns
  function automatic logic low_carry(input logic [FB-1:0] s, input logic [FB-1:0] c);
    logic [FB:0] t;
    t = {1'b0, s} + {1'b0, c};
    return t[FB];
  endfunction

  // sign of the clamped, floor-truncated fractional product
  function automatic logic frac_sign(input logic [W-1:0] a, input logic [W-1:0] b);
    return (a != '0) && (b != '0) && (a[W-1] ^ b[W-1]);
  endfunction

  logic [PW-1:0] a_ext;
  logic [PW-1:0] pp  [ROWS];
  logic [PW-1:0] rs  [ROWS-1];
  logic [PW-1:0] rc  [ROWS-1];

  assign a_ext = {{W{mul_a[W-1]}}, mul_a};

  generate
    for (genvar r = 0; r < W - 1; r++) begin : g_row
      assign pp[r] = mul_b[r] ? (a_ext << r) : '0;
    end
  endgenerate

  // sign-weight row: subtract a * 2^(W-1) as inverted row plus a unit row
  assign pp[W-1] = mul_b[W-1] ? ~(a_ext << (W - 1)) : '0;
  assign pp[W]   = {{(PW-1){1'b0}}, mul_b[W-1]};

  assign rs[0] = pp[0];
  assign rc[0] = pp[1];

  generate
    for (genvar k = 2; k < ROWS; k++) begin : g_red
      csa3 #(.N(PW)) u_csa (
        .in_x (rs[k-2]),
        .in_y (rc[k-2]),
        .in_z (pp[k]),
        .out_s(rs[k-1]),
        .out_c(rc[k-1])
      );
    end
  endgenerate

  logic [PW-1:0] fin_s;
  logic [PW-1:0] fin_c;
  logic          lc;

  assign fin_s = rs[ROWS-2];
  assign fin_c = rc[ROWS-2];
  assign lc    = low_carry(fin_s[FB-1:0], fin_c[FB-1:0]);

  assign sat_hit  = (mul_a == Q_MIN) && (mul_b == Q_MIN);
  assign vec_s    = sat_hit ? Q_MAX : fin_s[PW-2:FB];
  assign vec_c    = sat_hit ? '0    : fin_c[PW-2:FB];
  assign vec_cin  = sat_hit ? 1'b0  : lc;
  assign prod_neg = frac_sign(mul_a, mul_b);

  // R3: a clamped product is presented as the positive rail alone
  always_comb begin
    if (sat_hit) begin
      assert_prod_clamp_R3: assert ((vec_s == Q_MAX) && (vec_c == '0) && !vec_cin && !prod_neg)
        else $error("product clamp vectors wrong");
    end
  end

endmodule

// File: rtl/sat_add_sel.sv
module sat_add_sel #(
  parameter int unsigned W = 16
) (
  input  logic [W-1:0] addend,
  input  logic [W-1:0] vec_s,
  input  logic [W-1:0] vec_c,
  input  logic         vec_cin,
  input  logic         prod_neg,
  output logic [W-1:0] total,
  output logic         ovf_hit
);

  localparam logic [W-1:0] Q_MAX = {1'b0, {(W-1){1'b1}}};
  localparam logic [W-1:0] Q_MIN = {1'b1, {(W-1){1'b0}}};

  function automatic logic [W-1:0] rail(input logic neg);
    return neg ? Q_MIN : Q_MAX;
  endfunction

  function automatic logic sign_ovf(input logic sa, input logic sp, input logic sr);
    return (sa == sp) && (sr != sa);
  endfunction

  logic [W-1:0] cs_s;
  logic [W-1:0] cs_c;
  logic [W-1:0] raw;

  csa3 #(.N(W)) u_merge (
    .in_x (addend),
    .in_y (vec_s),
    .in_z (vec_c),
    .out_s(cs_s),
    .out_c(cs_c)
  );

  // the one carry-propagate adder of the datapath
  assign raw     = cs_s + cs_c + {{(W-1){1'b0}}, vec_cin};
  assign ovf_hit = sign_ovf(addend[W-1], prod_neg, raw[W-1]);
  assign total   = ovf_hit ? rail(addend[W-1]) : raw;

  // R4/R5: a clamp always lands on the rail named by the addend sign
  always_comb begin
    if (ovf_hit) begin
      assert_rail_sign_R5: assert (total[W-1] == addend[W-1] && (total == Q_MAX || total == Q_MIN))
        else $error("clamp rail mismatch");
    end
  end

endmodule

// File: rtl/sat_mac.sv
module sat_mac #(
  parameter int unsigned W = sat_mac_pkg::DEF_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] op_a,
  input  logic [W-1:0] op_b,
  input  logic [W-1:0] acc_in,
  input  logic         acc_src,
  input  logic         acc_en,
  input  logic         acc_clr,
  output logic [W-1:0] mac_out
);

  import sat_mac_pkg::*;

  localparam logic [W-1:0] Q_MAX = {1'b0, {(W-1){1'b1}}};
  localparam logic [W-1:0] Q_MIN = {1'b1, {(W-1){1'b0}}};

  logic [W-1:0] acc_q;
  logic [W-1:0] addend;
  logic [W-1:0] vs;
  logic [W-1:0] vc;
  logic         vcin;
  logic         p_neg;
  logic         mul_sat_ev;
  logic         add_ovf_ev;
  logic [W-1:0] next_val;

  assign addend = (addend_src_e'(acc_src) == SRC_EXT) ? acc_in : acc_q;

  frac_mul_cs #(.W(W)) u_mul (
    .mul_a   (op_a),
    .mul_b   (op_b),
    .vec_s   (vs),
    .vec_c   (vc),
    .vec_cin (vcin),
    .prod_neg(p_neg),
    .sat_hit (mul_sat_ev)
  );

  sat_add_sel #(.W(W)) u_add (
    .addend  (addend),
    .vec_s   (vs),
    .vec_c   (vc),
    .vec_cin (vcin),
    .prod_neg(p_neg),
    .total   (next_val),
    .ovf_hit (add_ovf_ev)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
    end else if (acc_clr) begin
      acc_q <= '0;
    end else if (acc_en) begin
      acc_q <= next_val;
    end
  end

  assign mac_out = acc_q;

  assert_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    acc_clr |=> (mac_out == '0));

  assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!acc_clr && !acc_en) |=> $stable(mac_out));

  assert_pos_rail_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_en && !acc_clr && add_ovf_ev && !addend[W-1]) |=> (mac_out == Q_MAX));

  assert_neg_rail_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_en && !acc_clr && add_ovf_ev && addend[W-1]) |=> (mac_out == Q_MIN));

  assert_min_square_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_en && !acc_clr && op_a == Q_MIN && op_b == Q_MIN && addend == '0) |=> (mac_out == Q_MAX));

  assert_no_double_ovf_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (mul_sat_ev && add_ovf_ev) |-> !addend[W-1]);

endmodule

// File: tb/sat_mac_bench.sv
module sat_mac_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] op_a = '0;
  logic [15:0] op_b = '0;
  logic [15:0] acc_in = '0;
  logic        acc_src = 1'b0;
  logic        acc_en = 1'b0;
  logic        acc_clr = 1'b0;
  logic [15:0] mac_out;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  logic [15:0] mdl = '0;
  logic [31:0] lfsr = 32'h1D2C_3B4A;

  always #10 clk = ~clk;

  sat_mac u_sat_mac (
    .clk(clk), .rst_n(rst_n), .op_a(op_a), .op_b(op_b), .acc_in(acc_in),
    .acc_src(acc_src), .acc_en(acc_en), .acc_clr(acc_clr), .mac_out(mac_out)
  );

  // serial reference: clamp the product, then clamp the sum
  function automatic logic [15:0] ref_mac(input logic [15:0] a, input logic [15:0] b,
                                          input logic [15:0] c);
    int sa, sb, pf, tot;
    sa = int'($signed(a));
    sb = int'($signed(b));
    if (sa == -32768 && sb == -32768) pf = 32767;
    else pf = (sa * sb) >>> 15;
    tot = int'($signed(c)) + pf;
    if (tot > 32767) tot = 32767;
    if (tot < -32768) tot = -32768;
    return tot[15:0];
  endfunction

  function automatic logic [15:0] corner(input int k, input logic [15:0] rnd);
    case (k)
      0: return 16'h0000;
      1: return 16'h0001;
      2: return 16'hFFFF;
      3: return 16'h7FFF;
      4: return 16'h8000;
      5: return 16'h8001;
      6: return 16'h4000;
      7: return 16'hC000;
      8: return 16'h7FFE;
      9: return 16'h0002;
      default: return rnd;
    endcase
  endfunction

  function automatic logic [31:0] lfsr_next(input logic [31:0] v);
    return {v[30:0], v[31] ^ v[21] ^ v[1] ^ v[0]};
  endfunction

  task automatic check(input string tag, input logic [15:0] exp);
    checks++;
    if (mac_out !== exp) begin
      errors++;
      $display("FAIL %s: mac_out=%h expected=%h", tag, mac_out, exp);
    end
  endtask

  task automatic step(input logic [15:0] a, input logic [15:0] b, input logic [15:0] ext,
                      input logic src, input logic en, input logic clr);
    op_a = a; op_b = b; acc_in = ext; acc_src = src; acc_en = en; acc_clr = clr;
    @(posedge clk);
    @(negedge clk);
    if (clr) mdl = '0;
    else if (en) mdl = ref_mac(a, b, src ? ext : mdl);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: mac_out=%h expected=finished", mac_out);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 in reset", 16'h0000);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after reset", 16'h0000);

    // R2 plain products
    step(16'h4000, 16'h4000, 16'h0000, 1'b1, 1'b1, 1'b0); check("R2 half*half", 16'h2000);
    step(16'hFFFF, 16'h0001, 16'h0000, 1'b1, 1'b1, 1'b0); check("R2 floor neg", 16'hFFFF);
    step(16'h4000, 16'hC000, 16'h1000, 1'b1, 1'b1, 1'b0); check("R2 mixed sign", 16'hF000);

    // R3 squared minimum clamps before the add
    step(16'h8000, 16'h8000, 16'hFFFF, 1'b1, 1'b1, 1'b0); check("R3 clamp then add", 16'h7FFE);
    step(16'h8000, 16'h8000, 16'h0001, 1'b1, 1'b1, 1'b0); check("R3 both clamps", 16'h7FFF);

    // R4 / R5 add rails
    step(16'h4000, 16'h4000, 16'h7000, 1'b1, 1'b1, 1'b0); check("R4 pos rail", 16'h7FFF);
    step(16'h4000, 16'hC000, 16'h8800, 1'b1, 1'b1, 1'b0); check("R5 neg rail", 16'h8000);
    step(16'h7FFF, 16'h8000, 16'h8000, 1'b1, 1'b1, 1'b0); check("R5 extreme", 16'h8000);

    // R8 clear beats enable
    step(16'h4000, 16'h4000, 16'h1234, 1'b1, 1'b1, 1'b1); check("R8 clear+enable", 16'h0000);

    // R6 accumulator feedback; acc_in ignored
    step(16'h4000, 16'h4000, 16'h7777, 1'b0, 1'b1, 1'b0); check("R6 reg addend 1", 16'h2000);
    step(16'h4000, 16'h4000, 16'h8888, 1'b0, 1'b1, 1'b0); check("R6 reg addend 2", 16'h4000);
    step(16'h4000, 16'h4000, 16'h8888, 1'b0, 1'b1, 1'b0); check("R6 reg addend 3", 16'h6000);
    step(16'h4000, 16'h4000, 16'h8888, 1'b0, 1'b1, 1'b0); check("R6 R4 running rail", 16'h7FFF);

    // R7 hold with operands moving
    step(16'h8000, 16'h8000, 16'h8000, 1'b1, 1'b0, 1'b0); check("R7 hold 1", 16'h7FFF);
    step(16'h1234, 16'hFEDC, 16'h0000, 1'b0, 1'b0, 1'b0); check("R7 hold 2", 16'h7FFF);
    step(16'h0000, 16'h0000, 16'h0000, 1'b0, 1'b0, 1'b1); check("R8 clear alone", 16'h0000);

    // R9 corner sweep with external addends
    for (int ia = 0; ia < 24; ia++) begin
      for (int ib = 0; ib < 24; ib++) begin
        for (int ic = 0; ic < 12; ic++) begin
          lfsr = lfsr_next(lfsr);
          step(corner(ia, lfsr[15:0]), corner(ib, lfsr[31:16]), corner(ic, lfsr[23:8]),
               1'b1, 1'b1, 1'b0);
          check("R9 sweep", mdl);
        end
      end
    end

    // R9 running accumulation with random control
    for (int n = 0; n < 12000; n++) begin
      logic [31:0] r1;
      lfsr = lfsr_next(lfsr);
      r1 = lfsr;
      lfsr = lfsr_next(lfsr);
      step(r1[15:0], r1[31:16], lfsr[15:0], lfsr[16], lfsr[17] | lfsr[18],
           (lfsr[23:19] == 5'd0));
      check("R9 random", mdl);
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule